// File: doc/BRIEF.md
# Message-Signalled Interrupt Request Generator with Re-arm Control

This block turns a set of per-port interrupt condition levels from a multi-port storage host controller into single message requests toward a bus interface. The condition lines are brought into the block clock, gathered into a live pending word, and whenever the generator is armed, enabled and sees any pending bit, it raises a request that stays up until the bus side takes it.

Once a request has been taken, the generator is blocked. It comes out of that state in one of two ways. Software can write a one to the self-clearing acknowledge bit of the control word. Otherwise every condition has to go away. A condition that shows up while others are still pending therefore starts no new message until software acknowledges. A write-one global reset bit returns the generator to its armed, disabled idle state. A small write/read register port gives access to the control word and to the pending word.

Top module: `msi_gen`

## Requirements
- R1: After reset `msi_req_valid_o` is low, and the control word (address 0) and the status word (address 1) both read as zero.
- R2: Reading address 1 returns the synchronised pending bits in bits [NPORTS-1:0] and zero above them. A condition change appears there SYNC_STAGES clock edges after it is sampled. Writes to address 1 change nothing.
- R3: When the generator is armed, enabled and any pending bit is set, `msi_req_valid_o` rises one edge later. It then stays high until a cycle with `msi_req_ready_i` high, even if the conditions or the enable drop in the meantime.
- R4: After a request is accepted, no new request is raised while any pending bit remains set and no acknowledge is written, including when further condition bits arrive.
- R5: When all pending bits are clear while blocked, the generator re-arms with no acknowledge, and the next condition produces a request.
- R6: Writing a one to control bit 30 (acknowledge) while blocked, with the enable set and a pending bit set, makes `msi_req_valid_o` high in the cycle right after the write. Bit 30 always reads as zero.
- R7: An acknowledge written while a request is outstanding, or while the generator is already armed, does not produce a second request.
- R8: Control bit 0 is the enable. While it is zero no request is raised. Setting it while conditions are pending and the generator is armed produces a request. It reads back as written.
- R9: Writing a one to control bit 31 (global reset) withdraws any outstanding request, clears the enable and re-arms the generator, and takes priority over the other bits of the same write. Bit 31 always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_cond_i | input | NPORTS | Per-port interrupt condition levels, asynchronous |
| msi_req_valid_o | output | 1 | Message request toward the bus interface |
| msi_req_ready_i | input | 1 | Bus side accepts the request this cycle |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Write address: 0 control, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_addr_i | input | ADDR_W | Read address: 0 control, 1 status |
| reg_rdata_o | output | 32 | Read data for reg_rd_addr_i, combinational |

## Verification
If the re-arm state is wrong, the fault shows up directly on `msi_req_valid_o`. A generator stuck blocked gives no request one edge after an acknowledge or after a fresh condition that follows an all-clear. A generator that fails to block gives a second request one or two cycles after acceptance while conditions are still pending. A wrong enable or synchronizer state shows up within one read cycle on the control or status word. For that reason the reference model is compared against the request line and the read data on every cycle. The stimulus walks through each re-arm path, back-pressure from the bus side, and a global reset that arrives during an outstanding request.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
    localparam int REG_W        = 32;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_ACK_BIT = 30;
    localparam int CTRL_RST_BIT = 31;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_REQ     = 2'd1,
        ST_BLOCKED = 2'd2
    } arm_state_e;

    typedef struct packed {
        arm_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic en;
    } ctrl_regs_t;
endpackage

// File: rtl/msi_cond_sync.sv
module msi_cond_sync #(
    parameter int NPORTS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] cond_i,
    output logic [NPORTS-1:0] pend_o
);
    logic [SYNC_STAGES-1:0][NPORTS-1:0] pipe_d, pipe_q;

    assign pipe_d[0] = cond_i;

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        assign pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign pend_o = pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/msi_ctrl_regs.sv
module msi_ctrl_regs
    import msi_gen_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_en_bit_i,
    input  logic              wr_ack_bit_i,
    input  logic              wr_rst_bit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NPORTS-1:0] pend_i,
    output logic              en_o,
    output logic              ack_o,
    output logic              grst_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

    ctrl_regs_t r_d, r_q;
    logic       ctrl_wr;

    always_comb begin
        ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);
        r_d     = r_q;
        if (ctrl_wr) begin
            if (wr_rst_bit_i) r_d.en = 1'b0;
            else              r_d.en = wr_en_bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o   = r_q.en;
    assign grst_o = ctrl_wr && wr_rst_bit_i;
    assign ack_o  = ctrl_wr && wr_ack_bit_i && !wr_rst_bit_i;

    always_comb begin
        rdata_o = '0;
        if (rd_addr_i == CTRL_ADDR)      rdata_o[CTRL_EN_BIT] = r_q.en;
        else if (rd_addr_i == STAT_ADDR) rdata_o[NPORTS-1:0]  = pend_i;
    end
endmodule

// File: rtl/msi_arm_fsm.sv
module msi_arm_fsm
    import msi_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pend_any_i,
    input  logic ack_i,
    input  logic grst_i,
    input  logic ready_i,
    output logic valid_o
);
    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            ST_ARMED: begin
                if (en_i && pend_any_i) f_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (ready_i) f_d.state = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (ack_i)           f_d.state = (en_i && pend_any_i) ? ST_REQ : ST_ARMED;
                else if (!pend_any_i) f_d.state = ST_ARMED;
            end
            default: f_d.state = ST_ARMED;
        endcase
        if (grst_i) f_d.state = ST_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_ARMED};
        else        f_q <= f_d;
    end

    assign valid_o = (f_q.state == ST_REQ);
endmodule

// File: rtl/msi_gen.sv
module msi_gen
    import msi_gen_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_cond_i,
    output logic              msi_req_valid_o,
    input  logic              msi_req_ready_i,
    input  logic              reg_wr_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [ADDR_W-1:0] reg_rd_addr_i,
    output logic [REG_W-1:0]  reg_rdata_o
);
    logic [NPORTS-1:0] pend_sync;
    logic              ctrl_en;
    logic              ack_pulse;
    logic              grst_pulse;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata_i[CTRL_ACK_BIT-1:CTRL_EN_BIT+1];

    msi_cond_sync #(.NPORTS(NPORTS), .SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (port_cond_i),
        .pend_o (pend_sync)
    );

    msi_ctrl_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (reg_wr_en_i),
        .wr_addr_i    (reg_addr_i),
        .wr_en_bit_i  (reg_wdata_i[CTRL_EN_BIT]),
        .wr_ack_bit_i (reg_wdata_i[CTRL_ACK_BIT]),
        .wr_rst_bit_i (reg_wdata_i[CTRL_RST_BIT]),
        .rd_addr_i    (reg_rd_addr_i),
        .pend_i       (pend_sync),
        .en_o         (ctrl_en),
        .ack_o        (ack_pulse),
        .grst_o       (grst_pulse),
        .rdata_o      (reg_rdata_o)
    );

    msi_arm_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_en),
        .pend_any_i (|pend_sync),
        .ack_i      (ack_pulse),
        .grst_i     (grst_pulse),
        .ready_i    (msi_req_ready_i),
        .valid_o    (msi_req_valid_o)
    );
endmodule

// File: rtl/msi_gen_chk.sv
module msi_gen_chk #(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_ack,
    input logic              wr_rst,
    input logic              en_q,
    input logic [NPORTS-1:0] pend
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == '0);

    // R3: an untaken request stays up
    a_r3_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !(ctrl_wr && wr_rst)) |=> valid);

    // R4: acceptance blocks, so no back-to-back request
    a_r4_block_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);

    // R6: acknowledge with pending work re-issues on the next cycle
    a_r6_ack_reissues: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_ack && !wr_rst && en_q && (|pend) && !valid) |=> valid);

    // R8: no request starts without the enable
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(en_q));

    // R9: global reset withdraws the request and clears the enable
    a_r9_global_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_rst) |=> (!valid && !en_q));
endmodule

bind msi_gen msi_gen_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (msi_req_valid_o),
    .ready   (msi_req_ready_i),
    .wr_en   (reg_wr_en_i),
    .wr_addr (reg_addr_i),
    .wr_ack  (reg_wdata_i[30]),
    .wr_rst  (reg_wdata_i[31]),
    .en_q    (ctrl_en),
    .pend    (pend_sync)
);

// File: tb/msi_gen_tb.sv
`timescale 1ns/1ps
module msi_gen_tb_top;
    localparam int NP   = 4;
    localparam int SYNC = 2;
    localparam int AW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] cond = '0;
    logic          ready = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          valid;
    logic [31:0]   rdata;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    msi_gen #(.NPORTS(NP), .SYNC_STAGES(SYNC), .ADDR_W(AW)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .port_cond_i     (cond),
        .msi_req_valid_o (valid),
        .msi_req_ready_i (ready),
        .reg_wr_en_i     (wr_en),
        .reg_addr_i      (wr_addr),
        .reg_wdata_i     (wdata),
        .reg_rd_addr_i   (rd_addr),
        .reg_rdata_o     (rdata)
    );

    // behavioural reference: a pending flag for the outstanding request,
    // a blocked flag, an enable and a delay queue for the conditions
    bit      m_req, m_blk, m_en;
    int      m_pend;
    int      sq[$];

    always @(posedge clk) begin
        int  p;
        bit  e, ack, rst_w, ctl;
        if (!rst_n) begin
            m_req = 0; m_blk = 0; m_en = 0; m_pend = 0; sq.delete();
        end else begin
            p     = m_pend;
            e     = m_en;
            ctl   = wr_en && (wr_addr == 0);
            rst_w = ctl && wdata[31];
            ack   = ctl && wdata[30] && !wdata[31];
            if (rst_w) begin
                m_req = 0; m_blk = 0; m_en = 0;
            end else begin
                if (ctl) m_en = wdata[0];
                if (m_req) begin
                    if (ready) begin m_req = 0; m_blk = 1; end
                end else if (m_blk) begin
                    if (ack || p == 0) m_blk = 0;
                    if (ack && e && p != 0) m_req = 1;
                end else if (e && p != 0) begin
                    m_req = 1;
                end
            end
            sq.push_back(int'(cond));
            if (sq.size() > SYNC) void'(sq.pop_front());
            m_pend = (sq.size() == SYNC) ? sq[0] : 0;
        end
    end

    always @(negedge clk) begin
        logic [31:0] exp_rd;
        cyc++;
        exp_rd = 32'h0;
        if (rd_addr == 0)      exp_rd = {31'h0, m_en};
        else if (rd_addr == 1) exp_rd = 32'(m_pend);
        n_vec++;
        if (valid !== m_req) begin
            n_bad++;
            $display("FAIL %s cycle %0d valid actual=%b expected=%b", cur_req, cyc, valid, m_req);
        end
        n_vec++;
        if (rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s cycle %0d rdata actual=%h expected=%h", cur_req, cyc, rdata, exp_rd);
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog cycle %0d actual=running expected=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wdata = d;
        step(1);
        wr_en = 1'b0; wdata = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1: reset state of request line and both words
        cur_req = "R1"; rd_addr = 0; step(2); rd_addr = 1; step(2);
        // R2: status word follows conditions after the synchronizer, writes ignored
        cur_req = "R2"; cond = 4'b0101; step(4);
        wr(1, 32'hFFFF_FFFF); step(1);
        cond = 4'b1010; step(4);
        // R8: disabled generator stays quiet, then enable with pending -> request
        cur_req = "R8"; step(3);
        rd_addr = 0; wr(0, 32'h1); step(3);
        // R4: additional condition while blocked raises nothing
        cur_req = "R4"; rd_addr = 1; cond = 4'b1011; step(6);
        // R6: acknowledge re-issues next cycle; R3: held under back-pressure
        cur_req = "R6"; ready = 1'b0; rd_addr = 0; wr(0, 32'h4000_0001);
        cur_req = "R3"; step(4); ready = 1'b1; step(3);
        // R7: acknowledge while request outstanding gives no second one
        cur_req = "R7"; ready = 1'b0; wr(0, 32'h4000_0001); step(1);
        wr(0, 32'h4000_0001); step(1); ready = 1'b1; step(4);
        // R5: full drop re-arms without acknowledge
        cur_req = "R5"; cond = 4'b0000; step(5);
        cond = 4'b0100; step(5);
        // R9: global reset during an outstanding request
        cur_req = "R9"; ready = 1'b0; wr(0, 32'h4000_0001); step(2);
        wr(0, 32'hC000_0001); step(3);
        wr(0, 32'h1); step(3); ready = 1'b1; step(3);
        // R8: enable cleared while armed, condition returns, no request until set
        cur_req = "R8"; cond = 4'b0000; step(4);
        wr(0, 32'h0); cond = 4'b0001; step(5);
        wr(0, 32'h1); step(4);
        // R5: second all-clear with enable kept, new port -> request
        cur_req = "R5"; cond = 4'b0000; step(4); cond = 4'b1000; step(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule